// File: doc/BRIEF.md
# Two-Product Floating-Point Dot-Product Accumulator

This block keeps a running single-precision sum and, on each accepted step, folds two fresh products into it: the new accumulator value is `acc + op_a*op_b + op_c*op_d`, rounded once to nearest-even. Both products are formed exactly. The accumulator and the two products are then brought to the largest of their three exponents, summed in one signed three-way add, normalized and rounded. A long dot product of N products therefore takes about N/2 steps.

The input side is a valid/ready stream. A step is taken on a clock edge where `in_valid` and `in_ready` are both high. The step then occupies two pipeline registers: the aligned sum, and the rounded accumulator. `in_ready` stays low until the result has been presented and, if `out_valid` is high, until `out_ready` has taken it. The output side is also valid/ready. `res` always shows the accumulator. `out_valid` marks a freshly computed step and holds, with `res` unchanged, while `out_ready` is low.

The plain `clr` input starts a new sum. Only normal numbers and zero are handled. Operands whose exponent field is 0 count as zero. Results above the normal range become infinity of the result's sign, and results below it become +0.

Top module: `fdp_acc`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `res` is 0x00000000.
- R2: A step accepted at a clock edge raises `out_valid` at the second following edge, with `res` equal to acc + op_a*op_b + op_c*op_d rounded once. The word layout is IEEE single precision: sign in bit 31, biased exponent in bits 30:23, fraction in 22:0.
- R3: An operand with exponent field 0 counts as zero, whatever its fraction bits; a product with such a factor adds nothing and does not affect alignment.
- R4: If the three addends are all zero, or if they cancel exactly, the result is +0 (0x00000000), never -0.
- R5: Terms of opposite sign subtract, and the result sign follows the sign of the exact sum, including a change of sign of the accumulator.
- R6: Rounding is to nearest with ties to even, applied once to the three-term sum, so that two sub-half remainders that together pass half an ULP round up.
- R7: `clr` high in a cycle with `in_ready` high and no step sets `res` to +0 at the next edge without raising `out_valid`; `clr` high together with an accepted step makes that step use zero as the accumulator.
- R8: `in_ready` is 0 in the cycle after a step is accepted, and `in_valid` and `clr` have no effect while `in_ready` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `res` holds its value and `in_ready` is 0.
- R10: A rounded exponent of 255 or more gives infinity with the sum's sign (exponent 0xFF, fraction 0); a rounded exponent of 0 or less gives +0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Start a new sum from zero |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set |
| op_a | input | 32 | First factor of product one |
| op_b | input | 32 | Second factor of product one |
| op_c | input | 32 | First factor of product two |
| op_d | input | 32 | Second factor of product two |
| out_valid | output | 1 | `res` carries a new step result |
| out_ready | input | 1 | Consumer takes the result |
| res | output | 32 | Current accumulator value |

## Verification
A fault in alignment, in the three-way add or in normalization shows as a wrong `res` word two edges after the step that exercised it. Because the wrong value is fed back, every later step in the same sum is also off. The directed cases are chosen so that each stage has a visible signature. Operands one ULP apart around 2^24 expose guard, sticky and tie handling. Mixed signs expose the two's-complement path and the choice of result sign. Exact cancellation exposes the zero and sign rules. Handshake faults show within one or two cycles as a wrong `in_ready` or `out_valid` level, or as `res` changing during a stall.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int FW   = 23;          // fraction bits
  localparam int EW   = 8;           // exponent bits
  localparam int MANW = FW + 1;      // significand with hidden one
  localparam int PW   = 2 * MANW;    // exact product width
  localparam int XW   = 11;          // signed internal exponent width
  localparam int BIAS = (1 << (EW - 1)) - 1;

  typedef logic signed [XW-1:0] exp_t;

  // exponent given to zero terms so they never win the maximum
  localparam exp_t ZERO_EXP = 11'sh600;
endpackage

// File: rtl/fdp_mul.sv
module fdp_mul #(
  parameter int W = 24
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  logic [2*W-1:0] s, c, pp, nc;

  // carry-save chain over the partial products, one carry-propagate add at the end
  always_comb begin
    s = '0;
    c = '0;
    for (int i = 0; i < W; i++) begin
      pp = y[i] ? ({{W{1'b0}}, x} << i) : '0;
      nc = ((s & c) | (s & pp) | (c & pp)) << 1;
      s  = s ^ c ^ pp;
      c  = nc;
    end
    p = s + c;
  end

  always_comb begin
    // R2
    if (x[W-1] && y[W-1])
      prod_norm_chk: assert (p[2*W-1] || p[2*W-2]);
  end
endmodule

// File: rtl/fdp_align_add.sv
module fdp_align_add
  import fdp_pkg::*;
#(
  parameter int EXT = 80,
  localparam int AW = PW + EXT,
  localparam int SW = AW + 3
) (
  input  logic [31:0]          op_a,
  input  logic [31:0]          op_b,
  input  logic [31:0]          op_c,
  input  logic [31:0]          op_d,
  input  logic [31:0]          acc,
  output logic signed [SW-1:0] sum,
  output exp_t                 emax
);
  logic [31:0]   fx [2];
  logic [31:0]   fy [2];
  logic [PW-1:0] prod [2];

  assign fx[0] = op_a;
  assign fy[0] = op_b;
  assign fx[1] = op_c;
  assign fy[1] = op_d;

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_mul
      fdp_mul #(.W(MANW)) u_mul (
        .x ({1'b1, fx[k][FW-1:0]}),
        .y ({1'b1, fy[k][FW-1:0]}),
        .p (prod[k])
      );
    end
  endgenerate

  exp_t          ex  [3];
  logic [PW-1:0] sig [3];
  logic          sgn [3];
  exp_t          e01;
  logic [XW-1:0] sh;
  logic [AW-1:0] full, mask, mag;
  logic [SW-1:0] ext;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      if ((|fx[t][30:23]) && (|fy[t][30:23])) begin
        ex[t]  = exp_t'({3'b000, fx[t][30:23]}) + exp_t'({3'b000, fy[t][30:23]})
                 - exp_t'(BIAS - 1);
        sig[t] = prod[t];
      end else begin
        ex[t]  = ZERO_EXP;
        sig[t] = '0;
      end
      sgn[t] = fx[t][31] ^ fy[t][31];
    end
    if (|acc[30:23]) begin
      ex[2]  = exp_t'({3'b000, acc[30:23]});
      sig[2] = {1'b1, acc[FW-1:0], {MANW{1'b0}}};
    end else begin
      ex[2]  = ZERO_EXP;
      sig[2] = '0;
    end
    sgn[2] = acc[31];

    e01  = (ex[0] > ex[1]) ? ex[0] : ex[1];
    emax = (e01 > ex[2]) ? e01 : ex[2];

    sum = '0;
    for (int t = 0; t < 3; t++) begin
      sh   = emax - ex[t];
      full = {sig[t], {EXT{1'b0}}};
      mask = ~({AW{1'b1}} << sh);
      mag  = (full >> sh) | AW'(|(full & mask));
      ext  = {3'b000, mag};
      sum  = sum + (sgn[t] ? -ext : ext);
    end
  end
endmodule

// File: rtl/fdp_norm_round.sv
module fdp_norm_round
  import fdp_pkg::*;
#(
  parameter int SW = 131,
  localparam int MW = SW - 1
) (
  input  logic signed [SW-1:0] sum,
  input  exp_t                 emax,
  output logic [31:0]          res
);
  logic          neg, lsb, grd, stk, up, cy;
  logic [SW-1:0] absv;
  logic [MW-1:0] mag, norm;
  logic [FW-1:0] frac;
  int            lz;
  exp_t          eres;

  always_comb begin
    neg  = sum[SW-1];
    absv = neg ? -sum : sum;
    mag  = absv[MW-1:0];
    lz   = MW;
    for (int i = 0; i < MW; i++)
      if (mag[i]) lz = MW - 1 - i;
    norm = mag << lz;
    lsb  = norm[MW-1-FW];
    grd  = norm[MW-2-FW];
    stk  = |norm[MW-3-FW:0];
    up   = grd & (stk | lsb);
    {cy, frac} = {1'b0, norm[MW-2 -: FW]} + (FW+1)'(up);
    eres = emax + exp_t'(2) - exp_t'(lz) + exp_t'(cy);
    if (mag == '0)
      res = '0;
    else if (eres >= exp_t'(255))
      res = {neg, 8'hFF, {FW{1'b0}}};
    else if (eres <= exp_t'(0))
      res = '0;
    else
      res = {neg, eres[EW-1:0], frac};
  end

  always_comb begin
    // R2
    if (mag != '0)
      norm_lead_chk: assert (norm[MW-1]);
  end
endmodule

// File: rtl/fdp_acc.sv
module fdp_acc
  import fdp_pkg::*;
#(
  parameter int EXT = 80,
  localparam int AW = PW + EXT,
  localparam int SW = AW + 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [31:0] op_c,
  input  logic [31:0] op_d,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] res
);
  logic                 fire, s1_vld;
  logic [31:0]          acc, acc_in, rnd;
  logic signed [SW-1:0] sum_c, s1_sum;
  exp_t                 emax_c, s1_emax;

  assign in_ready = !s1_vld && !(out_valid && !out_ready);
  assign fire     = in_valid && in_ready;
  assign acc_in   = clr ? '0 : acc;
  assign res      = acc;

  fdp_align_add #(.EXT(EXT)) u_add (
    .op_a (op_a), .op_b (op_b), .op_c (op_c), .op_d (op_d),
    .acc  (acc_in),
    .sum  (sum_c),
    .emax (emax_c)
  );

  fdp_norm_round #(.SW(SW)) u_rnd (
    .sum  (s1_sum),
    .emax (s1_emax),
    .res  (rnd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_sum    <= '0;
      s1_emax   <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
    end else begin
      s1_vld <= fire;
      if (fire) begin
        s1_sum  <= sum_c;
        s1_emax <= emax_c;
      end
      if (s1_vld) begin
        acc       <= rnd;
        out_valid <= 1'b1;
      end else begin
        if (out_valid && out_ready) out_valid <= 1'b0;
        if (clr && in_ready && !in_valid) acc <= '0;
      end
    end
  end

  // R2
  step_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ##2 out_valid);
  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !in_ready);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res)));
  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && in_ready && !in_valid) |=> (res == 32'h0));
  // R4
  no_negzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res[30:0] == 31'h0) |-> !res[31]);
  // R10
  no_subnorm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res[30:23] != 8'h00 || res[22:0] == 23'h0));
endmodule

// File: tb/tb_fdp_acc.sv
module tb_fdp_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
  logic        in_ready, out_valid;
  logic [31:0] res;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fdp_acc dut (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .in_valid (in_valid), .in_ready (in_ready),
    .op_a (op_a), .op_b (op_b), .op_c (op_c), .op_d (op_d),
    .out_valid (out_valid), .out_ready (out_ready), .res (res)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [31:0] a, b, cc, d);
    clr = c; in_valid = 1'b1;
    op_a = a; op_b = b; op_c = cc; op_d = d;
  endtask

  // one accepted step, checked for timing and value
  task automatic step(input logic c, input logic [31:0] a, b, cc, d,
                      input logic [31:0] exp, input string req);
    @(negedge clk);
    drive(c, a, b, cc, d);
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    check("R8 in_ready low after accept", {31'b0, in_ready}, 32'd0);
    check("R2 out_valid not yet", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    check("R2 out_valid after two edges", {31'b0, out_valid}, 32'd1);
    check(req, res, exp);
  endtask

  task automatic t_reset;
    check("R1 in_ready", {31'b0, in_ready}, 32'd1);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 res", res, 32'h0);
  endtask

  task automatic t_basic;
    step(1'b1, 32'h40000000, 32'h40400000, 32'h40800000, 32'h40a00000, 32'h41d00000, "R2 2*3+4*5");
    step(1'b0, 32'h3f800000, 32'h3f800000, 32'h3f000000, 32'h40000000, 32'h41e00000, "R2 26+1+1");
    step(1'b1, 32'h44800000, 32'h44800000, 32'h3f000000, 32'h3f800000, 32'h49800004, "R2 2^20+0.5 alignment");
  endtask

  task automatic t_signs;
    step(1'b1, 32'h40000000, 32'h40400000, 32'hbf800000, 32'h41200000, 32'hc0800000, "R5 6-10");
    step(1'b0, 32'h3f800000, 32'h3f800000, 32'h3f800000, 32'h3f800000, 32'hc0000000, "R5 -4+2");
    step(1'b0, 32'h3f800000, 32'h40a00000, 32'h0, 32'h0, 32'h40400000, "R5 sign flip -2+5");
  endtask

  task automatic t_zero;
    step(1'b1, 32'h40400000, 32'h40800000, 32'hc0000000, 32'h40c00000, 32'h0, "R4 12-12");
    step(1'b1, 32'h00400000, 32'h7f000000, 32'h3f800000, 32'h3f800000, 32'h3f800000, "R3 exp-0 operand is zero");
    step(1'b1, 32'h80000000, 32'h3f800000, 32'h0, 32'h0, 32'h0, "R4 -0 product gives +0");
    step(1'b1, 32'hc0800000, 32'h3f800000, 32'h0, 32'h0, 32'hc0800000, "R5 load -4");
    step(1'b0, 32'h40000000, 32'h40000000, 32'h0, 32'h0, 32'h0, "R4 acc cancels to +0");
  endtask

  task automatic t_round;
    step(1'b1, 32'h4b800000, 32'h3f800000, 32'h0, 32'h0, 32'h4b800000, "R6 load 2^24");
    step(1'b0, 32'h3f800000, 32'h3f800000, 32'h0, 32'h0, 32'h4b800000, "R6 tie down to even");
    step(1'b0, 32'h3f800000, 32'h3f800000, 32'h3f800000, 32'h40000000, 32'h4b800002, "R6 tie up to even");
    step(1'b0, 32'h3f800000, 32'h3f800000, 32'h3f000000, 32'h3f800000, 32'h4b800003, "R6 above half");
    step(1'b1, 32'h4b800000, 32'h3f800000, 32'h0, 32'h0, 32'h4b800000, "R6 reload 2^24");
    step(1'b0, 32'h3f400000, 32'h3f800000, 32'h3f400000, 32'h3f800000, 32'h4b800001, "R6 single rounding");
  endtask

  task automatic t_clear;
    step(1'b1, 32'h3f800000, 32'h3f800000, 32'h3f800000, 32'h3f800000, 32'h40000000, "R7 step with clr");
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R7 clr zeroes res", res, 32'h0);
    check("R7 clr no out_valid", {31'b0, out_valid}, 32'd0);
    @(negedge clk); drive(1'b0, 32'h3f800000, 32'h3f800000, 32'h3f800000, 32'h3f800000);
    @(negedge clk); drive(1'b1, 32'h40a00000, 32'h40a00000, 32'h0, 32'h0);
    @(negedge clk); in_valid = 1'b0; clr = 1'b0;
    check("R8 clr while busy ignored", res, 32'h40000000);
    @(negedge clk);
    check("R8 busy input not taken", res, 32'h40000000);
    check("R8 no extra result", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_stall;
    out_ready = 1'b0;
    @(negedge clk); drive(1'b1, 32'h3f800000, 32'h3f800000, 32'h0, 32'h0);
    @(negedge clk); in_valid = 1'b0; clr = 1'b0;
    @(negedge clk);
    check("R9 result 1.0", res, 32'h3f800000);
    check("R9 in_ready low in stall", {31'b0, in_ready}, 32'd0);
    drive(1'b0, 32'h40a00000, 32'h40a00000, 32'h0, 32'h0);
    repeat (2) begin
      @(negedge clk);
      check("R9 out_valid held", {31'b0, out_valid}, 32'd1);
      check("R9 res held", res, 32'h3f800000);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R9 out_valid drops after take", {31'b0, out_valid}, 32'd0);
    check("R9 stalled input not taken", res, 32'h3f800000);
  endtask

  task automatic t_range;
    step(1'b1, 32'h7f000000, 32'h40000000, 32'h0, 32'h0, 32'h7f800000, "R10 overflow +inf");
    step(1'b1, 32'hff000000, 32'h40000000, 32'h0, 32'h0, 32'hff800000, "R10 overflow -inf");
    step(1'b1, 32'h00800000, 32'h3f000000, 32'h0, 32'h0, 32'h0, "R10 underflow to +0");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_signs();
    t_zero();
    t_round();
    t_clear();
    t_stall();
    t_range();
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule